// File: doc/BRIEF.md
# MAC Address Hash Filter Engine

This block keeps a hashed table of 48-bit station addresses for a receive filter. For each request it folds the address into an 11-bit slot number. It then walks a 2048-slot external table by linear probing, and either reports what it finds (lookup) or changes the table (insert or delete). The receive path issues lookups for destination addresses. Host logic issues inserts and deletes to program the filter.

Each table slot is one 64-bit word, read and written through a simple synchronous port. A read returns data one cycle after the address is presented. The low 32 bits hold the flags and part of the address, and the high 32 bits hold the rest of the address. The engine handles one request at a time. It accepts a request only while `req_ready` is high and returns a single-cycle response pulse.

Top module: `mac_hash_filter`

## Requirements
- R1: The first slot probed is `{L[3:2], A1^A2^A3}`, built as follows. In every byte of the address, the two nibbles are swapped and then the bit order inside each nibble is reversed. H is the transformed `req_mac[47:32]` and L is the transformed `req_mac[31:0]`. The fields are A1=`{L[14:8],L[1:0]}`, A2=`L[23:15]` and A3=`{H[0],L[31:24]}`.
- R2: In a written entry, with h=`req_mac[47:32]` and l=`req_mac[31:0]`, the low word is `{l[20], l[19:16], l[31:28], l[27:24], h[7:4], h[3:0], h[15:12], h[11:8], rd, skip, 1}`. The high word is `{13'b0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21]}`. The low word sits in `tbl_wdata[31:0]` and the high word in `tbl_wdata[63:32]`.
- R3: Low-word bit 0 marks a slot valid, bit 1 is the skip flag and bit 2 is the receive flag. They are taken from `req_skip` and `req_rd` on insert.
- R4: Successive probes of one request use consecutive slots, and slot 2047 is followed by slot 0.
- R5: A slot matches when it is valid, its low word agrees with the request entry in bits 31:3, and its high word is equal. Inserting an address that is already stored rewrites that slot with the new flags and reports `resp_hit`=1.
- R6: Insert (`req_op`=1) writes the first probed slot that is invalid or matching, and reports that slot in `resp_slot`.
- R7: An insert that probes 12 slots without finding a free or matching one raises `resp_full` and writes nothing.
- R8: Delete (`req_op`=2) writes zero to both words of the matching slot and reports `resp_hit`=1. If no match is found before an invalid slot or within 12 probes, it reports `resp_hit`=0 and the table is unchanged.
- R9: Lookup (`req_op`=0 or 3) reports `resp_hit` together with the stored skip and receive flags when it finds a match. It ends with a miss at the first invalid slot or after 12 probes.
- R10: The response arrives 2·p cycles after the accepting clock edge, where p is the number of slots probed, and p is never more than 12.
- R11: `req_ready` is low from acceptance until the response, and a `req_valid` raised during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 lookup, 1 insert, 2 delete, 3 lookup |
| req_mac | input | 48 | Address, first byte in bits 47:40 |
| req_rd | input | 1 | Receive flag for insert |
| req_skip | input | 1 | Skip flag for insert |
| req_ready | output | 1 | Engine idle, request accepted |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | A matching slot was found |
| resp_full | output | 1 | Insert found no room |
| resp_skip | output | 1 | Skip flag of the hit slot (lookup) |
| resp_rd | output | 1 | Receive flag of the hit slot (lookup) |
| resp_slot | output | 11 | Slot where the search ended |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_addr | output | 11 | Table slot address |
| tbl_wdata | output | 64 | Table write data {high, low} |
| tbl_rdata | input | 64 | Table read data, one cycle after a read |

## Verification
Every probe costs one read cycle and one evaluate cycle. The response of a request that probes p slots is therefore due exactly 2·p clock edges after acceptance. The bench counts falling edges from the accepting edge until `resp_valid` and compares that count with the probe count it expects for the table contents it preloaded: 2 for an empty slot, 4 across the wrap, and 24 for a full chain. Table contents are inspected in the bench's memory model only after the response, by which time any write has landed.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int IDX_W = 11;
  localparam int MAC_W = 48;
  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    OP_LOOKUP  = 2'd0,
    OP_INSERT  = 2'd1,
    OP_DELETE  = 2'd2,
    OP_LOOKUP2 = 2'd3
  } op_e;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } slot_t;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
(
  input  logic [MAC_W-1:0] mac,
  output logic [IDX_W-1:0] idx
);
  localparam int NBYTES = MAC_W / 8;

  logic [MAC_W-1:0] rev;

  // nibble swap followed by per-nibble bit reversal equals a full byte reversal
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign rev[b*8+i] = mac[b*8+7-i];
    end
  end

  logic [31:0] lw;
  logic [15:0] hw;
  logic [8:0]  f1, f2, f3;

  assign lw = rev[31:0];
  assign hw = rev[47:32];
  assign f1 = {lw[14:8], lw[1:0]};
  assign f2 = lw[23:15];
  assign f3 = {hw[0], lw[31:24]};
  // the 6-bit field at lw[7:2] shifted by 9 keeps only lw[3:2] in 11 bits
  assign idx = {lw[3:2], f1 ^ f2 ^ f3};
endmodule

// File: rtl/mhf_entry_pack.sv
module mhf_entry_pack
  import mhf_pkg::*;
(
  input  logic [MAC_W-1:0] mac,
  input  logic             rd,
  input  logic             skip,
  output slot_t            ent
);
  logic [15:0] h;
  logic [31:0] l;

  assign h = mac[47:32];
  assign l = mac[31:0];

  assign ent.lo = {l[20], l[19:16], l[31:28], l[27:24],
                   h[7:4], h[3:0], h[15:12], h[11:8],
                   rd, skip, 1'b1};
  assign ent.hi = {13'd0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21]};
endmodule

// File: rtl/mhf_probe_ctl.sv
module mhf_probe_ctl
  import mhf_pkg::*;
#(
  parameter int HOPS = 12
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  slot_t             req_ent,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_full,
  output logic              resp_skip,
  output logic              resp_rd,
  output logic [IDX_W-1:0]  resp_slot,
  output logic              tbl_rd_en,
  output logic              tbl_wr_en,
  output logic [IDX_W-1:0]  tbl_addr,
  output logic [WORD_W-1:0] tbl_wdata,
  input  logic [WORD_W-1:0] tbl_rdata
);
  localparam int CNT_W = $clog2(HOPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EVAL} state_e;

  state_e           state;
  op_e              op_q;
  slot_t            ent_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  slot_t seen;
  logic  is_free, is_match, is_last;
  logic  finish, do_write, hit_now, full_now;

  assign seen     = slot_t'(tbl_rdata);
  assign is_free  = ~seen.lo[0];
  assign is_match = seen.lo[0] && (seen.lo[31:3] == ent_q.lo[31:3]) && (seen.hi == ent_q.hi);
  assign is_last  = (cnt_q == CNT_W'(HOPS - 1));

  always_comb begin
    finish   = 1'b0;
    do_write = 1'b0;
    hit_now  = 1'b0;
    full_now = 1'b0;
    if (state == S_EVAL) begin
      unique case (op_q)
        OP_INSERT: begin
          if (is_free || is_match) begin
            finish   = 1'b1;
            do_write = 1'b1;
            hit_now  = is_match;
          end else if (is_last) begin
            finish   = 1'b1;
            full_now = 1'b1;
          end
        end
        OP_DELETE: begin
          if (is_match) begin
            finish   = 1'b1;
            do_write = 1'b1;
            hit_now  = 1'b1;
          end else if (is_free || is_last) begin
            finish = 1'b1;
          end
        end
        default: begin
          if (is_match) begin
            finish  = 1'b1;
            hit_now = 1'b1;
          end else if (is_free || is_last) begin
            finish = 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign tbl_rd_en = (state == S_READ);
  assign tbl_wr_en = do_write;
  assign tbl_addr  = idx_q;
  assign tbl_wdata = (op_q == OP_DELETE) ? '0 : ent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_LOOKUP;
      ent_q      <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_full  <= 1'b0;
      resp_skip  <= 1'b0;
      resp_rd    <= 1'b0;
      resp_slot  <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q  <= op_e'(req_op);
            ent_q <= req_ent;
            idx_q <= req_idx;
            cnt_q <= '0;
            state <= S_READ;
          end
        end
        S_READ: state <= S_EVAL;
        default: begin
          if (finish) begin
            resp_valid <= 1'b1;
            resp_hit   <= hit_now;
            resp_full  <= full_now;
            resp_skip  <= (op_q == OP_LOOKUP || op_q == OP_LOOKUP2) && hit_now && seen.lo[1];
            resp_rd    <= (op_q == OP_LOOKUP || op_q == OP_LOOKUP2) && hit_now && seen.lo[2];
            resp_slot  <= idx_q;
            state      <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            cnt_q <= cnt_q + 1'b1;
            state <= S_READ;
          end
        end
      endcase
    end
  end

  // R10: never more than HOPS reads in one request
  a_r10_read_bound: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_en |-> (cnt_q < CNT_W'(HOPS)));

  // R4: each later probe addresses the slot after the previous read
  a_r4_consecutive: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd_en && cnt_q != '0) |-> (tbl_addr == $past(tbl_addr, 2) + 1'b1));

  // R7: a full report is never accompanied by a table write
  a_r7_full_no_write: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_full) |-> !$past(tbl_wr_en));

  // R11: the engine is idle again when a response appears
  a_r11_ready_on_resp: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

  // R10: the response is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R9: hit and full never reported together
  a_r9_hit_excl_full: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !(resp_hit && resp_full));
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mhf_pkg::*;
#(
  parameter int HOPS = 12
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [MAC_W-1:0]  req_mac,
  input  logic              req_rd,
  input  logic              req_skip,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_full,
  output logic              resp_skip,
  output logic              resp_rd,
  output logic [IDX_W-1:0]  resp_slot,
  output logic              tbl_rd_en,
  output logic              tbl_wr_en,
  output logic [IDX_W-1:0]  tbl_addr,
  output logic [WORD_W-1:0] tbl_wdata,
  input  logic [WORD_W-1:0] tbl_rdata
);
  logic [IDX_W-1:0] home_idx;
  slot_t            new_ent;

  mhf_hash u_hash (
    .mac (req_mac),
    .idx (home_idx)
  );

  mhf_entry_pack u_pack (
    .mac  (req_mac),
    .rd   (req_rd),
    .skip (req_skip),
    .ent  (new_ent)
  );

  mhf_probe_ctl #(.HOPS(HOPS)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_idx    (home_idx),
    .req_ent    (new_ent),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_full  (resp_full),
    .resp_skip  (resp_skip),
    .resp_rd    (resp_rd),
    .resp_slot  (resp_slot),
    .tbl_rd_en  (tbl_rd_en),
    .tbl_wr_en  (tbl_wr_en),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata),
    .tbl_rdata  (tbl_rdata)
  );
endmodule

// File: tb/sim_mac_hash_filter.sv
`timescale 1ns/1ps
module sim_mac_hash_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [47:0] req_mac = '0;
  logic        req_rd = 1'b0;
  logic        req_skip = 1'b0;
  logic        req_ready, resp_valid, resp_hit, resp_full, resp_skip, resp_rd;
  logic [10:0] resp_slot;
  logic        tbl_rd_en, tbl_wr_en;
  logic [10:0] tbl_addr;
  logic [63:0] tbl_wdata;
  logic [63:0] tbl_rdata = '0;

  logic [63:0] mem [2048];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic        r_hit, r_full, r_skip, r_rd;
  logic [10:0] r_slot;
  int          r_lat;

  localparam logic [63:0] FOREIGN = {32'hFFF8_0000, 32'h0000_0001};
  localparam logic [47:0] MA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MB = 48'h0A_BC_DE_F0_12_34;
  localparam logic [47:0] MC = 48'h00_50_C2_00_00_01;

  // {op, mac, rd, skip, exp_hit, exp_full}; for lookups rd/skip are the expected flags
  localparam int NV = 10;
  localparam logic [53:0] VEC [NV] = '{
    {2'd1, MA, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, MB, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, MA, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd0, MB, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd0, MC, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, MA, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd3, MA, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd2, MA, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd0, MA, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd2, MC, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  mac_hash_filter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_mac(req_mac),
    .req_rd(req_rd), .req_skip(req_skip), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_full(resp_full), .resp_skip(resp_skip), .resp_rd(resp_rd),
    .resp_slot(resp_slot), .tbl_rd_en(tbl_rd_en), .tbl_wr_en(tbl_wr_en), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tbl_wr_en) mem[tbl_addr] <= tbl_wdata;
    if (tbl_rd_en) tbl_rdata <= mem[tbl_addr];
  end

  function automatic logic [10:0] ref_idx(input logic [47:0] m);
    logic [47:0] t;
    logic [31:0] l;
    logic [15:0] h;
    logic [8:0]  x1, x2, x3;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by, sw;
      by = m[b*8 +: 8];
      sw = {by[3:0], by[7:4]};
      t[b*8 +: 8] = {sw[4], sw[5], sw[6], sw[7], sw[0], sw[1], sw[2], sw[3]};
    end
    l  = t[31:0];
    h  = t[47:32];
    x1 = {l[14:8], l[1:0]};
    x2 = l[23:15];
    x3 = {h[0], l[31:24]};
    return 11'(({26'd0, l[7:2]} << 9) | {23'd0, x1 ^ x2 ^ x3});
  endfunction

  function automatic logic [63:0] ref_ent(input logic [47:0] m, input logic rd, input logic sk);
    logic [15:0] h;
    logic [31:0] l;
    h = m[47:32];
    l = m[31:0];
    return {13'd0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21],
            l[20], l[19:16], l[31:28], l[27:24], h[7:4], h[3:0], h[15:12], h[11:8], rd, sk, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = '0;
  endtask

  task automatic start_req(input logic [1:0] op, input logic [47:0] m, input logic rd, input logic sk);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_mac = m; req_rd = rd; req_skip = sk;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp();
    int c;
    c = 0;
    while (!resp_valid && c < 200) begin
      @(negedge clk);
      c++;
    end
    if (c >= 200) chk(1'b0, "R10 response timeout", 64'(c), 64'd200);
    r_hit = resp_hit; r_full = resp_full; r_skip = resp_skip; r_rd = resp_rd;
    r_slot = resp_slot; r_lat = c;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [47:0] m, input logic rd, input logic sk);
    start_req(op, m, rd, sk);
    wait_resp();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [10:0] h;
    logic [47:0] w;
    logic [63:0] keep;
    clear_mem();
    repeat (3) @(negedge clk);
    // reset state
    chk(req_ready == 1'b1 && resp_valid == 1'b0, "R11 reset idle", {req_ready, resp_valid}, 64'b10);
    chk(tbl_wr_en == 1'b0 && tbl_rd_en == 1'b0, "R10 reset table port quiet", {tbl_rd_en, tbl_wr_en}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // vector walk on an empty table
    for (int v = 0; v < NV; v++) begin
      logic [53:0] e;
      e = VEC[v];
      run_op(e[53:52], e[51:4], e[3], e[2]);
      chk(r_hit == e[1], $sformatf("R5 R8 R9 vec%0d hit", v), 64'(r_hit), 64'(e[1]));
      chk(r_full == e[0], $sformatf("R7 vec%0d full", v), 64'(r_full), 64'(e[0]));
      if (e[53:52] == 2'd0 || e[53:52] == 2'd3)
        chk({r_rd, r_skip} == e[3:2], $sformatf("R9 R3 vec%0d flags", v), {r_rd, r_skip}, 64'(e[3:2]));
    end

    // R1 R2 R3: home slot and stored encoding on an empty table
    clear_mem();
    run_op(2'd1, MC, 1'b1, 1'b1);
    h = ref_idx(MC);
    chk(r_slot == h, "R1 home slot", 64'(r_slot), 64'(h));
    chk(r_lat == 2, "R10 one probe latency", 64'(r_lat), 64'd2);
    chk(mem[h] == ref_ent(MC, 1'b1, 1'b1), "R2 R3 stored entry", mem[h], ref_ent(MC, 1'b1, 1'b1));
    run_op(2'd1, MC, 1'b0, 1'b0);
    chk(r_hit && r_slot == h && mem[h] == ref_ent(MC, 1'b0, 1'b0), "R5 rewrite flags", mem[h], ref_ent(MC, 1'b0, 1'b0));

    // R4 R6: wrap from 2047 to 0
    w = '0;
    for (int k = 0; k < 65536; k++) begin
      w = {32'h0200_0000, 16'(k)};
      if (ref_idx(w) == 11'd2047) break;
    end
    clear_mem();
    mem[2047] = FOREIGN;
    run_op(2'd1, w, 1'b0, 1'b0);
    chk(r_slot == 11'd0, "R4 wrap to slot 0", 64'(r_slot), 64'd0);
    chk(r_lat == 4, "R10 two probe latency", 64'(r_lat), 64'd4);
    chk(mem[0] == ref_ent(w, 1'b0, 1'b0) && mem[2047] == FOREIGN, "R6 first free slot", mem[0], ref_ent(w, 1'b0, 1'b0));

    // R7: twelve occupied slots
    clear_mem();
    h = ref_idx(MA);
    for (int i = 0; i < 12; i++) mem[11'(h + 11'(i))] = FOREIGN;
    run_op(2'd1, MA, 1'b1, 1'b0);
    chk(r_full == 1'b1 && r_hit == 1'b0, "R7 full reported", {r_full, r_hit}, 64'b10);
    chk(r_lat == 24, "R10 twelve probe latency", 64'(r_lat), 64'd24);
    chk(mem[11'(h + 11'd12)] == '0 && mem[11'(h + 11'd11)] == FOREIGN, "R7 no write when full",
        mem[11'(h + 11'd12)], 64'd0);
    run_op(2'd0, MA, 1'b0, 1'b0);
    chk(r_hit == 1'b0 && r_lat == 24, "R9 lookup miss after 12", 64'(r_lat), 64'd24);
    run_op(2'd2, MA, 1'b0, 1'b0);
    chk(r_hit == 1'b0 && mem[h] == FOREIGN, "R8 absent delete no change", mem[h], FOREIGN);

    // R11: request during a busy search is ignored
    keep = mem[ref_idx(MC)];
    start_req(2'd0, MA, 1'b0, 1'b0);
    chk(req_ready == 1'b0, "R11 busy not ready", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_op = 2'd1; req_mac = MC;
    @(negedge clk);
    req_valid = 1'b0;
    wait_resp();
    chk(r_hit == 1'b0, "R11 first request completes", 64'(r_hit), 64'd0);
    begin
      int extra;
      extra = 0;
      repeat (30) begin
        @(negedge clk);
        if (resp_valid) extra++;
      end
      chk(extra == 0, "R11 no second response", 64'(extra), 64'd0);
    end
    chk(mem[ref_idx(MC)] == keep, "R11 ignored insert left table", mem[ref_idx(MC)], keep);

    // R6: last slot of the window is free
    mem[11'(h + 11'd11)] = '0;
    run_op(2'd1, MA, 1'b1, 1'b0);
    chk(r_slot == 11'(h + 11'd11) && r_lat == 24, "R6 twelfth slot used", 64'(r_slot), 64'(11'(h + 11'd11)));

    // R8 delete hit zeroes the slot
    run_op(2'd2, MA, 1'b0, 1'b0);
    chk(r_hit == 1'b1 && mem[11'(h + 11'd11)] == '0, "R8 delete clears", mem[11'(h + 11'd11)], 64'd0);

    // R9: lookup stops at first invalid slot
    clear_mem();
    mem[h] = FOREIGN;
    mem[11'(h + 11'd2)] = ref_ent(MA, 1'b1, 1'b1);
    run_op(2'd0, MA, 1'b0, 1'b0);
    chk(r_hit == 1'b0 && r_lat == 4, "R9 stop at hole", 64'(r_lat), 64'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule